// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block searches, over several clock cycles, for the integer settings of a phase-locked loop that bring its output closest to a requested frequency. Two inputs are given in kHz: the frequency of the reference clock and the requested output frequency. The block returns three settings:

- a pre-divider M,
- a feedback multiplier N,
- an index PL into a table of post-divider ratios.

It also returns the error of the chosen setting and the output rate that the setting gives. All range limits are fixed by parameters.

A client drives the two frequencies and pulses `start`. `busy` is high while the block walks the candidate space. It visits one candidate state per clock, in a fixed order: PL outer, M middle, N inner. Candidates are pruned when the reference-over-M frequency or the VCO frequency leaves its window. The walk stops early on an exact match. When the walk ends, the results are registered and `done` pulses for one cycle. The block does not program a PLL.

Top module: `pllsrch_top`

## Requirements
- R1: During and after reset, until the first search ends, `busy` and `done` are 0, `m_o`, `n_o`, `pl_o` and `rate_o` are 0, and `err_o` is all ones.
- R2: The post-divider ratio for index 0 to 14 is, in order, 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32. The scoring of candidates uses this ratio, and so does `rate_o`.
- R3: The search is bounded by two indices, a low index and a high index.
  - The internal target T is twice `req_khz`. The VCO target V0 is T + floor(T/50).
  - The high bound is the ceiling of the VCO upper bound divided by V0. The low bound is the floor of 1,000,000 divided by V0.
  - Both bounds are clamped to 1..32. Each is then converted to the first index whose ratio is not below it, with index 14 as the cap.
  - The PL scan runs upward from the low index to the high index.
- R4: Limits. M runs 1..255. N is accepted only inside 8..255. An M is accepted only if floor(ref/M) lies in 12,000..38,000.
  - When floor(ref/M) is below 12,000, the M scan for the current PL ends.
  - When floor(ref/M) is above 38,000, that M is skipped.
- R5: A candidate VCO value is floor(ref·N/M). It is scored only if it lies between 1,000,000 and the VCO upper bound, inclusive. That bound is max(2,064,000, V0).
- R6: The score of a candidate is |round(VCO/ratio) − T|, where the division rounds half up. A candidate replaces the best one only if its score is strictly smaller. On a tie the earlier candidate in the scan order stays.
- R7: For each accepted M, N runs from floor(Vpl·M/ref) up to the ceiling of the same quotient, where Vpl = T·ratio(PL). If that floor is above 255, the M scan for the current PL ends.
- R8: A score of 0 ends the search at once and returns that candidate with `err_o` = 0.
- R9: If no candidate qualifies, the results are M = 255, N = 8, PL = 0 and `err_o` all ones.
- R10: Handshake.
  - `busy` rises in the cycle after `start` is sampled and falls in the same cycle that `done` rises.
  - `done` lasts one cycle.
  - The result outputs change only when `done` rises.
  - A `start` seen while `busy` is high is ignored, together with its inputs.
- R11: `rate_o` = floor(floor(ref·N / (M·ratio(PL))) / 2), computed from the returned settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a search when the block is idle |
| ref_khz | input | FREQ_W | Reference frequency in kHz, nonzero |
| req_khz | input | FREQ_W | Requested output frequency in kHz, nonzero |
| busy | output | 1 | A search is running |
| done | output | 1 | One-cycle pulse: the results are valid |
| m_o | output | M_W | Chosen pre-divider |
| n_o | output | N_W | Chosen feedback multiplier |
| pl_o | output | 4 | Chosen post-divider index |
| err_o | output | FREQ_W | Score of the chosen setting, all ones if no setting qualified |
| rate_o | output | FREQ_W | Output rate of the chosen setting in kHz |

## Verification
The main sweep crosses seven reference frequencies with nineteen requests, and the results are compared with an arithmetic model of the scan.

- References of 12,000 and 19,200 kHz allow only one or two values of M.
- A reference of 100,000 kHz makes the scan skip M values that are too small before it finds M values it accepts.
- Round requests hit exact matches and so test the early exit.
- Odd requests force a full scan and test the strict-improvement rule.
- A very small request leaves no candidate and returns the default settings.
- A very large request raises the VCO upper bound and limits the PL range to index 0.

A reference below the M window tests the no-candidate default. A second start given in mid-search tests that a start is ignored while the block is busy.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

  localparam int PL_W    = 4;
  localparam int PL_LAST = 14;

  typedef logic [63:0] wide_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_MSCAN,
    ST_NSCAN,
    ST_FIN
  } srch_st_e;

  // Post-divider ratio for an index; entries past the table decode as 1.
  function automatic logic [5:0] pl_ratio(input logic [PL_W-1:0] idx);
    case (idx)
      4'd0:    return 6'd1;
      4'd1:    return 6'd2;
      4'd2:    return 6'd3;
      4'd3:    return 6'd4;
      4'd4:    return 6'd5;
      4'd5:    return 6'd6;
      4'd6:    return 6'd8;
      4'd7:    return 6'd10;
      4'd8:    return 6'd12;
      4'd9:    return 6'd16;
      4'd10:   return 6'd12;
      4'd11:   return 6'd16;
      4'd12:   return 6'd20;
      4'd13:   return 6'd24;
      4'd14:   return 6'd32;
      default: return 6'd1;
    endcase
  endfunction

  // Lowest index whose ratio reaches r, capped at the last index.
  function automatic logic [PL_W-1:0] ratio_to_pl(input wide_t r);
    logic [PL_W-1:0] res;
    res = PL_W'(PL_LAST);
    for (int i = PL_LAST - 1; i >= 0; i--) begin
      if (wide_t'(pl_ratio(PL_W'(i))) >= r) res = PL_W'(i);
    end
    return res;
  endfunction

  function automatic wide_t div_safe(input wide_t a, input wide_t b);
    return (b == '0) ? '0 : a / b;
  endfunction

  function automatic wide_t ceil_div(input wide_t a, input wide_t b);
    return (b == '0) ? '0 : (a + b - 64'd1) / b;
  endfunction

  function automatic wide_t clamp_w(input wide_t v, input wide_t lo, input wide_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic wide_t abs_diff(input wide_t a, input wide_t b);
    return (a > b) ? a - b : b - a;
  endfunction

  // Integer division rounded half up.
  function automatic wide_t round_div(input wide_t v, input wide_t r);
    return div_safe(v + (r >> 1), r);
  endfunction

endpackage

// File: rtl/pllsrch_setup.sv
module pllsrch_setup
  import pllsrch_pkg::*;
#(
  parameter int FREQ_W    = 32,
  parameter int VCO_MIN   = 1000000,
  parameter int VCO_MAX   = 2064000,
  parameter int RATIO_MIN = 1,
  parameter int RATIO_MAX = 32
) (
  input  logic [FREQ_W-1:0] req_q,
  output wide_t             target,
  output wide_t             vmax_eff,
  output logic [PL_W-1:0]   pl_lo,
  output logic [PL_W-1:0]   pl_hi
);

  localparam wide_t VMIN_W = wide_t'(VCO_MIN);
  localparam wide_t VMAX_W = wide_t'(VCO_MAX);
  localparam wide_t RMIN_W = wide_t'(RATIO_MIN);
  localparam wide_t RMAX_W = wide_t'(RATIO_MAX);

  wide_t tv0;
  wide_t hi_ratio;
  wide_t lo_ratio;

  always_comb begin
    target   = wide_t'(req_q) << 1;
    tv0      = target + target / 64'd50;
    vmax_eff = (tv0 > VMAX_W) ? tv0 : VMAX_W;
    hi_ratio = clamp_w(ceil_div(vmax_eff, tv0), RMIN_W, RMAX_W);
    lo_ratio = clamp_w(div_safe(VMIN_W, tv0), RMIN_W, RMAX_W);
    pl_hi    = ratio_to_pl(hi_ratio);
    pl_lo    = ratio_to_pl(lo_ratio);
  end

endmodule

// File: rtl/pllsrch_scorer.sv
module pllsrch_scorer
  import pllsrch_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int M_W     = 8,
  parameter int N_W     = 8,
  parameter int VCO_MIN = 1000000
) (
  input  logic [FREQ_W-1:0] ref_q,
  input  logic [M_W-1:0]    cand_m,
  input  logic [N_W-1:0]    cand_n,
  input  logic [PL_W-1:0]   cand_pl,
  input  wide_t             target,
  input  wide_t             vmax_eff,
  output logic              in_win,
  output wide_t             score
);

  localparam wide_t VMIN_W = wide_t'(VCO_MIN);

  wide_t vco_w;
  wide_t ratio_w;
  wide_t lwv;

  always_comb begin
    ratio_w = wide_t'(pl_ratio(cand_pl));
    vco_w   = div_safe(wide_t'(ref_q) * wide_t'(cand_n), wide_t'(cand_m));
    lwv     = round_div(vco_w, ratio_w);
    in_win  = (vco_w >= VMIN_W) && (vco_w <= vmax_eff);
    score   = abs_diff(lwv, target);
  end

endmodule

// File: rtl/pllsrch_rate.sv
module pllsrch_rate
  import pllsrch_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int M_W    = 8,
  parameter int N_W    = 8
) (
  input  logic [FREQ_W-1:0] ref_q,
  input  logic [M_W-1:0]    sel_m,
  input  logic [N_W-1:0]    sel_n,
  input  logic [PL_W-1:0]   sel_pl,
  output logic [FREQ_W-1:0] rate
);

  wide_t num;
  wide_t den;

  always_comb begin
    num  = wide_t'(ref_q) * wide_t'(sel_n);
    den  = wide_t'(sel_m) * wide_t'(pl_ratio(sel_pl));
    rate = FREQ_W'(div_safe(num, den) >> 1);
  end

endmodule

// File: rtl/pllsrch_walker.sv
module pllsrch_walker
  import pllsrch_pkg::*;
#(
  parameter int FREQ_W    = 32,
  parameter int M_W       = 8,
  parameter int N_W       = 8,
  parameter int M_MIN     = 1,
  parameter int M_MAX     = 255,
  parameter int N_MIN     = 8,
  parameter int N_MAX     = 255,
  parameter int U_MIN     = 12000,
  parameter int U_MAX     = 38000,
  parameter int RATIO_MIN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] ref_khz,
  input  logic [FREQ_W-1:0] req_khz,
  input  wide_t             target,
  input  logic [PL_W-1:0]   pl_lo,
  input  logic [PL_W-1:0]   pl_hi,
  input  logic              in_win,
  input  wide_t             score,
  input  logic [FREQ_W-1:0] rate_calc,
  output logic [FREQ_W-1:0] ref_q,
  output logic [FREQ_W-1:0] req_q,
  output logic [M_W-1:0]    cur_m,
  output logic [N_W-1:0]    cur_n,
  output logic [PL_W-1:0]   cur_pl,
  output logic [M_W-1:0]    best_m,
  output logic [N_W-1:0]    best_n,
  output logic [PL_W-1:0]   best_pl,
  output logic [FREQ_W-1:0] best_err,
  output logic              ev_exact,
  output logic              busy,
  output logic              done,
  output logic [M_W-1:0]    m_o,
  output logic [N_W-1:0]    n_o,
  output logic [PL_W-1:0]   pl_o,
  output logic [FREQ_W-1:0] err_o,
  output logic [FREQ_W-1:0] rate_o
);

  localparam int MC_W = M_W + 1;
  localparam int NC_W = N_W + 1;
  localparam logic [MC_W-1:0] MMIN_C = MC_W'(M_MIN);
  localparam logic [MC_W-1:0] MMAX_C = MC_W'(M_MAX);
  localparam logic [NC_W-1:0] NMIN_C = NC_W'(N_MIN);
  localparam logic [NC_W-1:0] NMAX_C = NC_W'(N_MAX);
  localparam wide_t UMIN_W = wide_t'(U_MIN);
  localparam wide_t UMAX_W = wide_t'(U_MAX);
  localparam wide_t NMAX_W = wide_t'(N_MAX);
  localparam logic [PL_W-1:0] PL_DEF = ratio_to_pl(wide_t'(RATIO_MIN));

  srch_st_e        st;
  logic [MC_W-1:0] m_c;
  logic [NC_W-1:0] n_c;
  logic [NC_W-1:0] n_end;
  logic [PL_W-1:0] pl_c;

  wide_t u_f, tv_pl, prod, n_floor, n_ceil;

  // Arithmetic of the M level.
  always_comb begin
    u_f     = div_safe(wide_t'(ref_q), wide_t'(m_c));
    tv_pl   = target * wide_t'(pl_ratio(pl_c));
    prod    = tv_pl * wide_t'(m_c);
    n_floor = div_safe(prod, wide_t'(ref_q));
    n_ceil  = ceil_div(prod, wide_t'(ref_q));
  end

  // Named scan events.
  logic in_m, in_n;
  logic ev_m_over, ev_u_low, ev_u_high, ev_nfloor_over;
  logic ev_pl_next, ev_m_skip;
  logic ev_n_exhaust, ev_n_low, ev_n_cap, ev_eval, ev_improve;
  logic last_pl;

  assign in_m           = (st == ST_MSCAN);
  assign in_n           = (st == ST_NSCAN);
  assign ev_m_over      = in_m && (m_c > MMAX_C);
  assign ev_u_low       = in_m && !ev_m_over && (u_f < UMIN_W);
  assign ev_u_high      = in_m && !ev_m_over && !ev_u_low && (u_f > UMAX_W);
  assign ev_nfloor_over = in_m && !ev_m_over && !ev_u_low && !ev_u_high && (n_floor > NMAX_W);
  assign ev_pl_next     = ev_m_over || ev_u_low || ev_nfloor_over;
  assign ev_m_skip      = ev_u_high;
  assign ev_n_exhaust   = in_n && (n_c > n_end);
  assign ev_n_low       = in_n && !ev_n_exhaust && (n_c < NMIN_C);
  assign ev_n_cap       = in_n && !ev_n_exhaust && !ev_n_low && (n_c > NMAX_C);
  assign ev_eval        = in_n && !ev_n_exhaust && !ev_n_low && !ev_n_cap;
  assign ev_improve     = ev_eval && in_win && (score < wide_t'(best_err));
  assign ev_exact       = ev_improve && (score == '0);
  assign last_pl        = (pl_c >= pl_hi);

  assign cur_m  = M_W'(m_c);
  assign cur_n  = N_W'(n_c);
  assign cur_pl = pl_c;
  assign busy   = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ref_q    <= '0;
      req_q    <= '0;
      m_c      <= '0;
      n_c      <= '0;
      n_end    <= '0;
      pl_c     <= '0;
      best_m   <= '0;
      best_n   <= '0;
      best_pl  <= '0;
      best_err <= '1;
      done     <= 1'b0;
      m_o      <= '0;
      n_o      <= '0;
      pl_o     <= '0;
      err_o    <= '1;
      rate_o   <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            ref_q    <= ref_khz;
            req_q    <= req_khz;
            best_m   <= M_W'(M_MAX);
            best_n   <= N_W'(N_MIN);
            best_pl  <= PL_DEF;
            best_err <= '1;
            st       <= ST_INIT;
          end
        end
        ST_INIT: begin
          pl_c <= pl_lo;
          m_c  <= MMIN_C;
          st   <= ST_MSCAN;
        end
        ST_MSCAN: begin
          if (ev_pl_next) begin
            if (last_pl) begin
              st <= ST_FIN;
            end else begin
              pl_c <= pl_c + 1'b1;
              m_c  <= MMIN_C;
            end
          end else if (ev_m_skip) begin
            m_c <= m_c + 1'b1;
          end else begin
            n_c   <= NC_W'(n_floor);
            n_end <= NC_W'(n_ceil);
            st    <= ST_NSCAN;
          end
        end
        ST_NSCAN: begin
          if (ev_n_exhaust || ev_n_cap) begin
            m_c <= m_c + 1'b1;
            st  <= ST_MSCAN;
          end else begin
            if (ev_improve) begin
              best_m   <= M_W'(m_c);
              best_n   <= N_W'(n_c);
              best_pl  <= pl_c;
              best_err <= FREQ_W'(score);
            end
            if (ev_exact) st <= ST_FIN;
            else          n_c <= n_c + 1'b1;
          end
        end
        ST_FIN: begin
          m_o    <= best_m;
          n_o    <= best_n;
          pl_o   <= best_pl;
          err_o  <= best_err;
          rate_o <= rate_calc;
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pllsrch_top.sv
module pllsrch_top
  import pllsrch_pkg::*;
#(
  parameter int FREQ_W    = 32,
  parameter int M_W       = 8,
  parameter int N_W       = 8,
  parameter int M_MIN     = 1,
  parameter int M_MAX     = 255,
  parameter int N_MIN     = 8,
  parameter int N_MAX     = 255,
  parameter int U_MIN     = 12000,
  parameter int U_MAX     = 38000,
  parameter int VCO_MIN   = 1000000,
  parameter int VCO_MAX   = 2064000,
  parameter int RATIO_MIN = 1,
  parameter int RATIO_MAX = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] ref_khz,
  input  logic [FREQ_W-1:0] req_khz,
  output logic              busy,
  output logic              done,
  output logic [M_W-1:0]    m_o,
  output logic [N_W-1:0]    n_o,
  output logic [PL_W-1:0]   pl_o,
  output logic [FREQ_W-1:0] err_o,
  output logic [FREQ_W-1:0] rate_o
);

  logic [FREQ_W-1:0] ref_q, req_q, best_err, rate_calc;
  wide_t             target, vmax_eff, score;
  logic [PL_W-1:0]   pl_lo, pl_hi, cur_pl, best_pl;
  logic [M_W-1:0]    cur_m, best_m;
  logic [N_W-1:0]    cur_n, best_n;
  logic              in_win, ev_exact;

  pllsrch_setup #(
    .FREQ_W(FREQ_W), .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX),
    .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)
  ) setup_i (
    .req_q(req_q), .target(target), .vmax_eff(vmax_eff),
    .pl_lo(pl_lo), .pl_hi(pl_hi)
  );

  pllsrch_scorer #(
    .FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W), .VCO_MIN(VCO_MIN)
  ) scorer_i (
    .ref_q(ref_q), .cand_m(cur_m), .cand_n(cur_n), .cand_pl(cur_pl),
    .target(target), .vmax_eff(vmax_eff), .in_win(in_win), .score(score)
  );

  pllsrch_rate #(
    .FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W)
  ) rate_i (
    .ref_q(ref_q), .sel_m(best_m), .sel_n(best_n), .sel_pl(best_pl),
    .rate(rate_calc)
  );

  pllsrch_walker #(
    .FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W), .M_MIN(M_MIN), .M_MAX(M_MAX),
    .N_MIN(N_MIN), .N_MAX(N_MAX), .U_MIN(U_MIN), .U_MAX(U_MAX),
    .RATIO_MIN(RATIO_MIN)
  ) walker_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ref_khz(ref_khz), .req_khz(req_khz),
    .target(target), .pl_lo(pl_lo), .pl_hi(pl_hi),
    .in_win(in_win), .score(score), .rate_calc(rate_calc),
    .ref_q(ref_q), .req_q(req_q),
    .cur_m(cur_m), .cur_n(cur_n), .cur_pl(cur_pl),
    .best_m(best_m), .best_n(best_n), .best_pl(best_pl), .best_err(best_err),
    .ev_exact(ev_exact), .busy(busy), .done(done),
    .m_o(m_o), .n_o(n_o), .pl_o(pl_o), .err_o(err_o), .rate_o(rate_o)
  );

endmodule

// File: rtl/pllsrch_chk.sv
module pllsrch_chk
  import pllsrch_pkg::*;
#(
  parameter int FREQ_W    = 32,
  parameter int M_W       = 8,
  parameter int N_W       = 8,
  parameter int M_MIN     = 1,
  parameter int M_MAX     = 255,
  parameter int N_MIN     = 8,
  parameter int N_MAX     = 255,
  parameter int RATIO_MIN = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [FREQ_W-1:0] ref_q,
  input logic [FREQ_W-1:0] req_q,
  input logic [M_W-1:0]    m_o,
  input logic [N_W-1:0]    n_o,
  input logic [PL_W-1:0]   pl_o,
  input logic [FREQ_W-1:0] err_o,
  input logic [FREQ_W-1:0] rate_o,
  input logic [FREQ_W-1:0] best_err,
  input logic              ev_exact
);

  localparam logic [FREQ_W-1:0] NONE_ERR = '1;
  localparam logic [PL_W-1:0]   PL_DEF   = ratio_to_pl(wide_t'(RATIO_MIN));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ends_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_inputs_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ref_q) && $stable(req_q)));

  p_results_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(m_o) && $stable(n_o) && $stable(pl_o) && $stable(err_o) && $stable(rate_o)));

  p_best_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (best_err <= $past(best_err)));

  p_exact_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exact |=> ##1 (done && err_o == '0));

  p_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_o == NONE_ERR) |->
      (m_o == M_W'(M_MAX) && n_o == N_W'(N_MIN) && pl_o == PL_DEF));

  p_ranges_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_o != NONE_ERR) |->
      (m_o >= M_W'(M_MIN) && m_o <= M_W'(M_MAX) &&
       n_o >= N_W'(N_MIN) && n_o <= N_W'(N_MAX) && pl_o <= PL_W'(PL_LAST)));

endmodule

bind pllsrch_top pllsrch_chk #(
  .FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W), .M_MIN(M_MIN), .M_MAX(M_MAX),
  .N_MIN(N_MIN), .N_MAX(N_MAX), .RATIO_MIN(RATIO_MIN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .ref_q(ref_q), .req_q(req_q), .m_o(m_o), .n_o(n_o), .pl_o(pl_o),
  .err_o(err_o), .rate_o(rate_o), .best_err(best_err), .ev_exact(ev_exact)
);

// File: tb/pllsrch_top_tb_top.sv
module pllsrch_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_khz = '0;
  logic [31:0] req_khz = '0;
  logic        busy, done;
  logic [7:0]  m_o, n_o;
  logic [3:0]  pl_o;
  logic [31:0] err_o, rate_o;

  int checks = 0;
  int fails  = 0;

  localparam longint NONE = 64'd4294967295;

  always #5 clk = ~clk;

  pllsrch_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_khz(ref_khz), .req_khz(req_khz),
    .busy(busy), .done(done), .m_o(m_o), .n_o(n_o), .pl_o(pl_o),
    .err_o(err_o), .rate_o(rate_o)
  );

  function automatic longint ratio_of(int idx);
    int tbl [15] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32};
    return longint'(tbl[idx]);
  endfunction

  function automatic int idx_for(longint r);
    for (int i = 0; i < 14; i++) if (ratio_of(i) >= r) return i;
    return 14;
  endfunction

  function automatic longint lim(longint v);
    return (v < 1) ? 1 : ((v > 32) ? 32 : v);
  endfunction

  // Arithmetic model of the nested scan.
  task automatic model(input longint r, input longint q,
                       output longint em, output longint en, output longint ep,
                       output longint ee, output longint er);
    longint t, v0, vtop, u, lo_n, hi_n, vco, lwv, d, best, tv;
    int plo, phi;
    bit found;
    t = 2 * q;
    v0 = t + t / 50;
    vtop = (v0 > 2064000) ? v0 : 2064000;
    phi = idx_for(lim((vtop + v0 - 1) / v0));
    plo = idx_for(lim(1000000 / v0));
    em = 255; en = 8; ep = 0; best = NONE; found = 0;
    for (int p = plo; p <= phi && !found; p++) begin
      tv = t * ratio_of(p);
      for (int m = 1; m <= 255 && !found; m++) begin
        u = r / m;
        if (u < 12000) break;
        if (u > 38000) continue;
        lo_n = tv * m / r;
        hi_n = (tv * m + r - 1) / r;
        if (lo_n > 255) break;
        for (longint n = lo_n; n <= hi_n && !found; n++) begin
          if (n < 8) continue;
          if (n > 255) break;
          vco = r * n / m;
          if (vco >= 1000000 && vco <= vtop) begin
            lwv = (vco + ratio_of(p) / 2) / ratio_of(p);
            d = (lwv > t) ? lwv - t : t - lwv;
            if (d < best) begin
              best = d; em = m; en = n; ep = p;
              if (d == 0) found = 1;
            end
          end
        end
      end
    end
    ee = best;
    er = (r * en / (em * ratio_of(int'(ep)))) / 2;
  endtask

  task automatic compare(input string tag, input longint em, input longint en,
                         input longint ep, input longint ee, input longint er);
    checks++;
    if (longint'(m_o) != em || longint'(n_o) != en || longint'(pl_o) != ep ||
        longint'(err_o) != ee || longint'(rate_o) != er) begin
      fails++;
      $display("FAIL %s: got m=%0d n=%0d pl=%0d err=%0d rate=%0d, expected m=%0d n=%0d pl=%0d err=%0d rate=%0d",
               tag, m_o, n_o, pl_o, err_o, rate_o, em, en, ep, ee, er);
    end
  endtask

  task automatic flag(input string tag, input bit ok, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 40000; k++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
    flag("R10 search finished", ok, int'(ok), 1);
  endtask

  task automatic search(input int r, input int q);
    longint em, en, ep, ee, er;
    bit ok;
    string tag;
    @(negedge clk);
    ref_khz = r; req_khz = q; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    model(r, q, em, en, ep, ee, er);
    // Scan order and pruning (R3 R4 R5 R7), table (R2), rate (R11).
    if (ee == 0)         tag = $sformatf("R8 ref=%0d req=%0d R2 R3 R4 R5 R7 R11", r, q);
    else if (ee == NONE) tag = $sformatf("R9 ref=%0d req=%0d R2 R11", r, q);
    else                 tag = $sformatf("R6 ref=%0d req=%0d R2 R3 R4 R5 R7 R11", r, q);
    if (ok) compare(tag, em, en, ep, ee, er);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: got running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    int refs [7] = '{12000, 12800, 13000, 19200, 27000, 38400, 100000};
    int reqs [19] = '{36000, 54000, 90000, 126000, 162000, 198000, 234000, 270000,
                      306000, 324000, 342000, 354000, 378000, 402000, 426000,
                      100003, 77777, 500, 1500000};
    longint em, en, ep, ee, er;
    bit ok;

    repeat (3) @(negedge clk);
    // R1: reset values
    compare("R1 reset", 0, 0, 0, NONE, 0);
    flag("R1 busy/done in reset", (busy == 1'b0) && (done == 1'b0), int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compare("R1 after reset", 0, 0, 0, NONE, 0);

    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 19; j++)
        search(refs[i], reqs[j]);

    // R9: reference below the M window leaves no candidate
    search(5000, 300000);
    model(5000, 300000, em, en, ep, ee, er);
    flag("R9 default rate", (rate_o == 32'd78) && (er == 78), int'(rate_o), 78);

    // R10: busy timing, a start seen while busy is ignored, done is a pulse
    @(negedge clk);
    ref_khz = 12000; req_khz = 72000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    flag("R10 busy after start", busy == 1'b1, int'(busy), 1);
    @(negedge clk);
    ref_khz = 5000; req_khz = 300000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    model(12000, 72000, em, en, ep, ee, er);
    if (ok) compare("R10 start while busy ignored", em, en, ep, ee, er);
    flag("R10 busy low with done", busy == 1'b0, int'(busy), 0);
    @(negedge clk);
    flag("R10 done is one cycle", done == 1'b0, int'(done), 0);
    compare("R10 results held after done", em, en, ep, ee, er);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule